// File: doc/BRIEF.md
# CSMA/CD Transmit Controller

This block is the transmit-side access controller for a station on a shared, half-duplex medium. A frame arrives one byte per cycle over a valid/ready interface with a last-byte marker and is held in a local buffer. Once the whole frame is held, the controller waits for the carrier-sense input to report a quiet medium. It then drives the frame onto the line one byte per cycle, watching the collision input on every data byte.

A frame shorter than the minimum length is extended with zero bytes. This keeps the station on the line for a full slot period, so every other station sees a collision if one happens. When a collision is seen, the controller stops sending data at once and drives a short run of 0xAA jam bytes. It then waits a random whole number of slot times, chosen by truncated binary exponential backoff, and retries the same frame from its first byte.

The frame is dropped after the sixteenth collision, and an abort pulse is raised. A completed frame gives a one-cycle done pulse. Bytes past the buffer capacity are accepted and discarded.

Top module: `csma_tx_ctrl`

## Requirements
- R1: After reset `line_en`, `tx_done` and `tx_abort` are 0 and `in_ready` is 1.
- R2: `in_ready` is 1 only while the controller collects a frame. It drops in the cycle after the byte marked `in_last` is accepted and stays 0 until the frame completes or is dropped. `line_en` is never 1 while `in_ready` is 1.
- R3: Each transmission attempt begins in the cycle after `carrier_sense` is sampled low while waiting. While `carrier_sense` stays high, `line_en` stays 0.
- R4: Frame bytes appear on `line_data` with `line_en` = 1 in arrival order, one per cycle, with no gaps.
- R5: A frame of fewer than MIN_BYTES (default 64) bytes is followed on the line by 0x00 bytes up to MIN_BYTES in total. A longer frame is sent at its own length.
- R6: A collision sampled high during any data byte, including the final byte, ends the data. Collision takes precedence over completion, so no `tx_done` follows. In the next cycle exactly JAM_BYTES (4) bytes of 0xAA follow, and then `line_en` drops.
- R7: After the n-th collision of a frame (n < 16), the next first byte of the frame comes r*SLOT_BYTES+3 cycles after the last jam byte. Here r is an integer with 0 ≤ r ≤ 2^min(n,10)−1. The retry repeats the whole frame from its first byte.
- R8: On the sixteenth collision of a frame, the jam is sent and no retry follows. `tx_abort` is 1 for exactly the cycle after the last jam byte, and `in_ready` returns to 1 in that cycle.
- R9: `tx_done` is 1 for exactly the cycle after the final byte of a frame, never together with `tx_abort`. The collision count restarts at zero for the next frame.
- R10: The collision input has no effect outside data bytes: pulses during jam, backoff or frame collection change neither the jam length nor the retried bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one byte time |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Frame byte from upstream |
| in_valid | input | 1 | `in_data` holds a byte |
| in_last | input | 1 | Current byte ends the frame |
| in_ready | output | 1 | Controller is collecting a frame |
| carrier_sense | input | 1 | Medium busy |
| collision | input | 1 | Collision seen on the medium |
| line_data | output | 8 | Byte driven onto the medium |
| line_en | output | 1 | `line_data` is being driven |
| tx_done | output | 1 | One-cycle pulse: frame sent |
| tx_abort | output | 1 | One-cycle pulse: frame dropped after 16 collisions |

## Verification
A collision and the end of a frame can land in the same cycle, when the collision input is raised while the final byte (a zero pad byte at index 63) is on the line. The bench provokes exactly that case and expects the jam, a backoff and a full retry, with no `tx_done` before the retry has completed. Loading and jamming are provoked together with collision pulses to show that the input is only honoured on data bytes. Every line byte is judged against a scoreboard queue that the bench rewrites whenever it injects a collision.

// File: rtl/csma_tx_pkg.sv
package csma_tx_pkg;

  typedef enum logic [2:0] {
    ST_LOAD    = 3'd0,
    ST_DEFER   = 3'd1,
    ST_SEND    = 3'd2,
    ST_JAM     = 3'd3,
    ST_BACKOFF = 3'd4
  } tx_state_e;

  localparam logic [7:0] JAM_BYTE = 8'hAA;

  // 16-bit maximal-length Fibonacci LFSR, taps 16,14,13,11
  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/csma_frame_buf.sv
module csma_frame_buf #(
  parameter int MAX_BYTES = 128,
  parameter int IDX_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic [IDX_W-1:0] len
);
  localparam int AW = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  logic [7:0] mem [MAX_BYTES];
  wire        has_room = (len < IDX_W'(MAX_BYTES));

  always_ff @(posedge clk) begin
    if (wr_en && has_room) mem[len[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr)          len <= '0;
    else if (wr_en && has_room) len <= len + 1'b1;
  end

  // positions past the stored length read as zero padding
  assign rd_data = (rd_idx < len) ? mem[rd_idx[AW-1:0]] : 8'h00;

endmodule

// File: rtl/csma_backoff.sv
module csma_backoff
  import csma_tx_pkg::*;
#(
  parameter int SLOT_BYTES = 64,
  parameter int BO_CAP     = 10,
  parameter int TRY_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TRY_W-1:0]  tries,
  output logic [BO_CAP-1:0] slots,
  output logic              zero
);
  localparam int CNT_W = BO_CAP + $clog2(SLOT_BYTES + 1);

  logic [15:0]      lfsr;
  logic [CNT_W-1:0] cnt;

  // bits below min(n, BO_CAP) set: mask = 2^min(n,cap) - 1
  function automatic logic [BO_CAP-1:0] slot_mask(input logic [TRY_W-1:0] n);
    logic [BO_CAP-1:0] m;
    for (int i = 0; i < BO_CAP; i++) m[i] = (int'(n) > i);
    return m;
  endfunction

  function automatic logic [CNT_W-1:0] slot_cycles(input logic [BO_CAP-1:0] r);
    return CNT_W'(r) * CNT_W'(SLOT_BYTES);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= 16'hACE1;
    else        lfsr <= lfsr_step(lfsr);
  end

  assign slots = (lfsr[BO_CAP-1:0] ^ BO_CAP'(lfsr >> BO_CAP)) & slot_mask(tries);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= slot_cycles(slots);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/csma_tx_ctrl.sv
module csma_tx_ctrl
  import csma_tx_pkg::*;
#(
  parameter int SLOT_BYTES = 64,
  parameter int MIN_BYTES  = 64,
  parameter int MAX_BYTES  = 128,
  parameter int JAM_BYTES  = 4,
  parameter int MAX_TRIES  = 16,
  parameter int BO_CAP     = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  input  logic       carrier_sense,
  input  logic       collision,
  output logic [7:0] line_data,
  output logic       line_en,
  output logic       tx_done,
  output logic       tx_abort
);
  localparam int IDX_W = $clog2(MAX_BYTES + 1);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam int JAM_W = $clog2(JAM_BYTES + 1);

  tx_state_e         state;
  logic [IDX_W-1:0]  idx, buf_len, send_len;
  logic [TRY_W-1:0]  tries;
  logic [JAM_W-1:0]  jam_cnt;
  logic [7:0]        rd_byte;
  logic [BO_CAP-1:0] bo_slots;
  logic              bo_zero, done_q, abort_q;

  function automatic logic [IDX_W-1:0] wire_len(input logic [IDX_W-1:0] n);
    return (n < IDX_W'(MIN_BYTES)) ? IDX_W'(MIN_BYTES) : n;
  endfunction

  assign send_len = wire_len(buf_len);

  // named internal events
  wire in_send    = (state == ST_SEND);
  wire in_jam     = (state == ST_JAM);
  wire ev_accept  = (state == ST_LOAD) && in_valid;
  wire ev_start   = (state == ST_DEFER) && !carrier_sense;
  wire ev_hit     = in_send && collision;
  wire ev_last    = in_send && !collision && (idx == send_len - 1'b1);
  wire ev_jam_end = in_jam && (jam_cnt == JAM_W'(JAM_BYTES - 1));
  wire ev_give_up = ev_jam_end && (tries == TRY_W'(MAX_TRIES));
  wire ev_retry   = ev_jam_end && !ev_give_up;

  csma_frame_buf #(.MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ev_last || ev_give_up),
    .wr_en   (ev_accept),
    .wr_data (in_data),
    .rd_idx  (idx),
    .rd_data (rd_byte),
    .len     (buf_len)
  );

  csma_backoff #(.SLOT_BYTES(SLOT_BYTES), .BO_CAP(BO_CAP), .TRY_W(TRY_W)) u_bo (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ev_retry),
    .tries (tries),
    .slots (bo_slots),
    .zero  (bo_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_LOAD;
      idx     <= '0;
      tries   <= '0;
      jam_cnt <= '0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      done_q  <= ev_last;
      abort_q <= ev_give_up;
      case (state)
        ST_LOAD:    if (ev_accept && in_last) state <= ST_DEFER;
        ST_DEFER:   if (ev_start) begin
                      state <= ST_SEND;
                      idx   <= '0;
                    end
        ST_SEND:    if (ev_hit) begin
                      state   <= ST_JAM;
                      jam_cnt <= '0;
                      tries   <= tries + 1'b1;
                    end else if (ev_last) begin
                      state <= ST_LOAD;
                      tries <= '0;
                    end else begin
                      idx <= idx + 1'b1;
                    end
        ST_JAM:     if (ev_give_up) begin
                      state <= ST_LOAD;
                      tries <= '0;
                    end else if (ev_retry) begin
                      state <= ST_BACKOFF;
                    end else begin
                      jam_cnt <= jam_cnt + 1'b1;
                    end
        ST_BACKOFF: if (bo_zero) state <= ST_DEFER;
        default:    state <= ST_LOAD;
      endcase
    end
  end

  assign in_ready  = (state == ST_LOAD);
  assign line_en   = in_send || in_jam;
  assign line_data = in_send ? rd_byte : JAM_BYTE;
  assign tx_done   = done_q;
  assign tx_abort  = abort_q;

endmodule

// File: rtl/csma_tx_chk.sv
module csma_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       carrier_sense,
  input logic       collision,
  input logic       in_ready,
  input logic       line_en,
  input logic [7:0] line_data,
  input logic       tx_done,
  input logic       tx_abort,
  input logic       in_send
);
  // R3
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_en) |-> $past(!carrier_sense));

  // R6
  jam_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_send && collision) |=> (line_en && line_data == 8'hAA && !tx_done));

  // R2
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !line_en);

  // R9
  done_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> ($past(line_en) && !line_en && in_ready));

  // R8
  abort_after_jam_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> ($past(line_en) && $past(line_data) == 8'hAA && !line_en && in_ready));

  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({tx_done, tx_abort}) <= 1);

endmodule

bind csma_tx_ctrl csma_tx_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .carrier_sense (carrier_sense),
  .collision     (collision),
  .in_ready      (in_ready),
  .line_en       (line_en),
  .line_data     (line_data),
  .tx_done       (tx_done),
  .tx_abort      (tx_abort),
  .in_send       (in_send)
);

// File: tb/tb_csma_tx_ctrl.sv
module tb_csma_tx_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT = 4;
  localparam int MINB = 64;

  logic clk = 0, rst_n = 0;
  logic [7:0] in_data = 0;
  logic in_valid = 0, in_last = 0, carrier_sense = 0, collision = 0;
  logic in_ready, line_en, tx_done, tx_abort;
  logic [7:0] line_data;

  csma_tx_ctrl #(.SLOT_BYTES(SLOT), .MIN_BYTES(MINB)) dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .carrier_sense(carrier_sense),
    .collision(collision), .line_data(line_data), .line_en(line_en),
    .tx_done(tx_done), .tx_abort(tx_abort));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, last_hi = 0, bo_n = 0;
  int done_cnt = 0, abort_cnt = 0;
  bit prev_en = 0, ready_bad = 0, reported = 0;
  logic [7:0] exp_b[$];
  string      exp_t[$];
  logic [7:0] cur_frame[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops the scoreboard on every line byte
  always @(negedge clk) begin
    if (rst_n) begin
      if (line_en) begin
        if (!prev_en && bo_n > 0) begin
          int g, lim;
          g = cyc - last_hi - 3;
          lim = (1 << ((bo_n < 10) ? bo_n : 10)) - 1;
          check(g >= 0 && g % SLOT == 0 && g / SLOT <= lim, "R7 backoff gap", g, lim * SLOT);
          bo_n = 0;
        end
        if (exp_b.size() == 0) check(0, "R4 unexpected line byte", line_data, -1);
        else begin
          logic [7:0] e;
          string t;
          e = exp_b.pop_front();
          t = exp_t.pop_front();
          check(line_data == e, t, line_data, e);
        end
        if (in_ready) ready_bad = 1;
        last_hi = cyc;
      end
      if (tx_done) begin
        done_cnt++;
        check(last_hi == cyc - 1 && exp_b.size() == 0 && !line_en, "R9 done timing", cyc - last_hi, 1);
      end
      if (tx_abort) abort_cnt++;
      prev_en = line_en;
    end
  end

  task automatic push_frame(input string tag);
    foreach (cur_frame[i]) begin
      exp_b.push_back(cur_frame[i]);
      exp_t.push_back(tag);
    end
  endtask

  task automatic load_frame(input int len, input int seed);
    cur_frame.delete();
    for (int i = 0; i < len; i++) cur_frame.push_back(8'((seed + i * 3) & 255));
    for (int i = len; i < MINB; i++) cur_frame.push_back(8'h00);
    for (int i = 0; i < cur_frame.size(); i++) begin
      exp_b.push_back(cur_frame[i]);
      exp_t.push_back(i < len ? "R4 data byte" : "R5 zero pad");
    end
    while (!in_ready) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      in_valid = 1; in_data = 8'((seed + i * 3) & 255); in_last = (i == len - 1);
      @(negedge clk);
    end
    in_valid = 0; in_last = 0;
  endtask

  // collide on byte k of the next attempt; n = collision count of the frame
  task automatic collide(input int k, input int n, input bit final_hit, input bit noise);
    int cnt;
    while (line_en) @(negedge clk);
    do @(negedge clk); while (!line_en);
    cnt = 0;
    while (cnt < k) begin
      @(negedge clk);
      if (line_en) cnt++;
    end
    collision = 1;
    #1;
    exp_b.delete(); exp_t.delete();
    for (int i = 0; i < 4; i++) begin exp_b.push_back(8'hAA); exp_t.push_back("R6 jam byte"); end
    if (!final_hit) begin push_frame("R7 retry byte"); bo_n = n; end
    @(negedge clk); collision = 0;
    if (noise) begin
      @(negedge clk); collision = 1;   // during jam (R10)
      @(negedge clk); collision = 0;
      @(negedge clk);
      @(negedge clk); collision = 1;   // during backoff (R10)
      @(negedge clk); collision = 0;
    end
    if (final_hit) begin
      repeat (4) @(negedge clk);
      check(tx_abort && !line_en, "R8 abort after jam", tx_abort, 1);
      check(in_ready, "R8 ready after abort", in_ready, 1);
      @(negedge clk);
      check(!tx_abort, "R8 abort one cycle", tx_abort, 0);
    end
  endtask

  task automatic wait_done(input string tag);
    int start, t;
    start = done_cnt; t = 0;
    while (done_cnt == start && t < 30000) begin @(negedge clk); #1; t++; end
    check(done_cnt > start, tag, done_cnt - start, 1);
    check(exp_b.size() == 0, "R4 all bytes sent", exp_b.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", cyc, 200000);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!line_en, "R1 line_en after reset", line_en, 0);
    check(!tx_done, "R1 tx_done after reset", tx_done, 0);
    check(!tx_abort, "R1 tx_abort after reset", tx_abort, 0);
    check(in_ready, "R1 in_ready after reset", in_ready, 1);

    // R10: collision while collecting a frame is ignored; R5 short frame padded
    collision = 1;
    load_frame(10, 5);
    collision = 0;
    wait_done("R5 short frame done");

    // R5 long frame sent at own length
    load_frame(80, 17);
    wait_done("R5 long frame done");

    // R3 carrier busy defers; R2 ready low while holding a frame
    carrier_sense = 1;
    load_frame(70, 33);
    begin
      bit quiet = 1;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (line_en) quiet = 0; end
      check(quiet, "R3 held while carrier busy", !quiet, 0);
      check(!in_ready, "R2 ready low after last byte", in_ready, 0);
    end
    carrier_sense = 0;
    @(negedge clk);
    check(line_en, "R3 start after carrier idle", line_en, 1);
    wait_done("R3 deferred frame done");

    // R6/R7/R10 collisions with noise, growing backoff window
    load_frame(30, 7);
    collide(3, 1, 0, 1);
    collide(10, 2, 0, 0);
    collide(0, 3, 0, 1);
    wait_done("R7 retried frame done");

    // R6 collision on the final (pad) byte wins over completion
    load_frame(10, 9);
    collide(MINB - 1, 1, 0, 0);
    wait_done("R6 last-byte collision then done");

    // R8 sixteen collisions drop the frame
    begin
      int d0;
      d0 = done_cnt;
      load_frame(12, 21);
      for (int n = 1; n <= 16; n++) collide(2, n, n == 16, 0);
      repeat (5) @(negedge clk);
      check(done_cnt == d0, "R8 no done after abort", done_cnt - d0, 0);
      check(abort_cnt == 1, "R8 abort count", abort_cnt, 1);
      check(exp_b.size() == 0 && !line_en, "R8 nothing sent after abort", exp_b.size(), 0);
    end

    // R9 collision count restarts for the next frame (window of n=1)
    load_frame(15, 41);
    collide(4, 1, 0, 0);
    wait_done("R9 fresh frame done");

    check(!ready_bad, "R2 ready never with line_en", ready_bad, 0);
    repeat (5) @(negedge clk);
    report();
  end

endmodule